// File: doc/BRIEF.md
# Clear-on-read diagnostic status register

This block gathers error and status conditions from around the chip into one 16-bit diagnostic word. A host reads that word as two bytes over a simple register read port. Each condition sets a sticky flag, where 1 means error or active and 0 means normal. A read of either byte clears every flag. A condition that is still present sets its flag again on its next occurrence. The two supply monitors are sampled only on a sample strobe, so a supply that is still out of range latches again at the next sample cycle after a read.

A built-in frame checker watches the SPI chip select and serial clock, both already sampled into the block's clock domain. A state machine has three states:

- `FR_IDLE` waits for select to fall.
- `FR_ACTIVE` counts SCLK rising edges. The counter restarts when select falls.
- `FR_CLOSE` lasts one cycle after select rises. In this state it raises an error strobe if the edge count is not a multiple of the frame length (16 by default).

The transitions are:

- `FR_IDLE` to `FR_ACTIVE` on select falling.
- `FR_ACTIVE` to `FR_CLOSE` on select rising.
- `FR_CLOSE` to `FR_ACTIVE` if select falls again at once, otherwise to `FR_IDLE`.

The error strobe sets the SPI flag.

Top module: `diag_status_reg`

## Requirements
- R1: After reset every flag is 0, so both bytes of the word read 0x00.
- R2: Flag positions in the word: bit 0 supply low, bit 1 supply high, bit 2 flash update failed, bit 3 SPI frame error, bit 4 self-test running, bit 5 self-test failed, bit 6 checksum mismatch, bit 7 capture buffer full, bit 8 alarm 1, bit 9 alarm 2. Bits 15:10 always read 0. A flag set by its input stays 1 until a read clears it.
- R3: A read with `rd_en` high and `rd_addr` equal to `DIAG_ADDR` (even) returns word bits 7:0. A read at `DIAG_ADDR+1` returns bits 15:8. `rd_data` holds the byte from the cycle after `rd_en`.
- R4: A read of either byte clears all flags, so a read that follows with no new event returns 0.
- R5: An event in the same cycle as a clearing read leaves its flag at 1; set wins over clear.
- R6: The supply-low and supply-high inputs are levels that latch only in a cycle with `sample_tick` high. A level still present after a read latches again at the next tick.
- R7: On chip select rising, the SPI error flag is set when the number of SCLK rising edges since select fell is not a multiple of 16. Counts of 0, 16 and 32 set nothing.
- R8: A read at any address other than the two word addresses returns 0x00 and clears nothing.
- R9: The SCLK edge count restarts at every select fall, so a bad frame does not affect the frame after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read request, one cycle |
| rd_addr | input | 7 | Byte address of the read |
| rd_data | output | 8 | Read byte, valid the cycle after the request |
| sample_tick | input | 1 | Supply sample strobe |
| supply_low | input | 1 | Supply below lower limit (level) |
| supply_high | input | 1 | Supply above upper limit (level) |
| flash_fail | input | 1 | Flash update failure event |
| selftest_busy | input | 1 | Self-test running |
| selftest_fail | input | 1 | Self-test failure event |
| cksum_bad | input | 1 | Checksum mismatch event |
| capbuf_full | input | 1 | Capture buffer full |
| alarm1 | input | 1 | Alarm comparison 1 active |
| alarm2 | input | 1 | Alarm comparison 2 active |
| spi_sclk | input | 1 | Sampled SPI serial clock |
| spi_cs_n | input | 1 | Sampled SPI chip select, active low |

## Verification
The assertions check these properties on every cycle:

- No flag falls without a clearing read.
- An event is always visible in the next cycle, even when a read happens in the same cycle.
- A clearing read with no events empties the word.
- A miss read returns zero.
- The frame checker's counter restarts on select fall.
- The frame checker's error strobe follows only a select rise.

The bench scenarios are needed for the rest:

- Sweeping SCLK edge counts from 0 to 34 shows the modulo-16 rule for every count.
- Supply re-latching shows that a held level sets its flag again only at a sample tick.
- A bad frame followed by a good one shows the counter restart.
- Reading the correct byte for each flag confirms the bit positions.

// File: rtl/diag_pkg.sv
package diag_pkg;
    localparam int FLAG_N = 10;
    localparam int WORD_W = 16;

    localparam int B_SUP_LO  = 0;
    localparam int B_SUP_HI  = 1;
    localparam int B_FLASH   = 2;
    localparam int B_SPI     = 3;
    localparam int B_ST_BUSY = 4;
    localparam int B_ST_FAIL = 5;
    localparam int B_CKSUM   = 6;
    localparam int B_CAPFULL = 7;
    localparam int B_ALM1    = 8;
    localparam int B_ALM2    = 9;

    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_ACTIVE = 2'd1,
        FR_CLOSE  = 2'd2
    } frame_state_t;
endpackage

// File: rtl/diag_spi_framer.sv
module diag_spi_framer
    import diag_pkg::*;
#(
    parameter int FRAME_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    output logic frame_err
);
    localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);

    frame_state_t state, state_nx;
    logic [CNT_W-1:0] edge_cnt;
    logic sclk_q, cs_q;
    logic sclk_rise, cs_fall, cs_rise;

    assign sclk_rise = spi_sclk & ~sclk_q;
    assign cs_fall   = ~spi_cs_n & cs_q;
    assign cs_rise   = spi_cs_n & ~cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= spi_sclk;
            cs_q   <= spi_cs_n;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FR_IDLE:   if (cs_fall) state_nx = FR_ACTIVE;
            FR_ACTIVE: if (cs_rise) state_nx = FR_CLOSE;
            FR_CLOSE:  state_nx = cs_fall ? FR_ACTIVE : FR_IDLE;
            default:   state_nx = FR_IDLE;
        endcase
    end

    // edge counter, modulo FRAME_LEN
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt <= '0;
        end else if (cs_fall) begin
            edge_cnt <= '0;
        end else if (state == FR_ACTIVE && !spi_cs_n && sclk_rise) begin
            edge_cnt <= (edge_cnt == CNT_LAST) ? '0 : edge_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        frame_err = 1'b0;
        unique case (state)
            FR_CLOSE: frame_err = (edge_cnt != '0);
            default:  frame_err = 1'b0;
        endcase
    end

    // R9
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (edge_cnt == '0));

    // R7
    err_after_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(cs_rise));
endmodule

// File: rtl/diag_flag_bank.sv
module diag_flag_bank
    import diag_pkg::*;
#(
    parameter int N = FLAG_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_all,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flags[i] <= 1'b0;
            else if (set_vec[i]) flags[i] <= 1'b1;
            else if (clr_all)    flags[i] <= 1'b0;
        end
    end

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all |=> ((flags & $past(flags)) == $past(flags)));

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R4
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && set_vec == '0) |=> (flags == '0));
endmodule

// File: rtl/diag_read_port.sv
module diag_read_port
    import diag_pkg::*;
#(
    parameter int              ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] DIAG_ADDR = 7'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] word,
    output logic [7:0]        rd_data,
    output logic              rd_hit
);
    assign rd_hit = rd_en && (rd_addr[ADDR_W-1:1] == DIAG_ADDR[ADDR_W-1:1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_hit) rd_data <= rd_addr[0] ? word[15:8] : word[7:0];
        else             rd_data <= '0;
    end

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hit) |=> (rd_data == 8'h00));

    // R2
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && rd_addr[0]) |=> (rd_data[7:2] == 6'b0));
endmodule

// File: rtl/diag_status_reg.sv
module diag_status_reg
    import diag_pkg::*;
#(
    parameter int                ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] DIAG_ADDR = 7'h12,
    parameter int                FRAME_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              sample_tick,
    input  logic              supply_low,
    input  logic              supply_high,
    input  logic              flash_fail,
    input  logic              selftest_busy,
    input  logic              selftest_fail,
    input  logic              cksum_bad,
    input  logic              capbuf_full,
    input  logic              alarm1,
    input  logic              alarm2,
    input  logic              spi_sclk,
    input  logic              spi_cs_n
);
    localparam int PAD_W = WORD_W - FLAG_N;

    logic [FLAG_N-1:0] set_vec, flags;
    logic [WORD_W-1:0] word;
    logic frame_err, rd_hit;

    always_comb begin
        set_vec            = '0;
        set_vec[B_SUP_LO]  = supply_low  & sample_tick;
        set_vec[B_SUP_HI]  = supply_high & sample_tick;
        set_vec[B_FLASH]   = flash_fail;
        set_vec[B_SPI]     = frame_err;
        set_vec[B_ST_BUSY] = selftest_busy;
        set_vec[B_ST_FAIL] = selftest_fail;
        set_vec[B_CKSUM]   = cksum_bad;
        set_vec[B_CAPFULL] = capbuf_full;
        set_vec[B_ALM1]    = alarm1;
        set_vec[B_ALM2]    = alarm2;
    end

    assign word = {{PAD_W{1'b0}}, flags};

    diag_spi_framer #(.FRAME_LEN(FRAME_LEN)) u_framer (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .frame_err(frame_err)
    );

    diag_flag_bank #(.N(FLAG_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_all(rd_hit),
        .flags(flags)
    );

    diag_read_port #(.ADDR_W(ADDR_W), .DIAG_ADDR(DIAG_ADDR)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .word(word), .rd_data(rd_data), .rd_hit(rd_hit)
    );

    // R6
    supply_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_tick && rd_hit && set_vec == '0) |=> !flags[B_SUP_LO] && !flags[B_SUP_HI]);
endmodule

// File: tb/tb_diag_status_reg.sv
module tb_diag_status_reg;
    localparam logic [6:0] A_LO = 7'h12;
    localparam logic [6:0] A_HI = 7'h13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en = 1'b0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic sample_tick = 0, supply_low = 0, supply_high = 0, flash_fail = 0;
    logic selftest_busy = 0, selftest_fail = 0, cksum_bad = 0, capbuf_full = 0;
    logic alarm1 = 0, alarm2 = 0, spi_sclk = 0, spi_cs_n = 1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    diag_status_reg dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .sample_tick(sample_tick), .supply_low(supply_low), .supply_high(supply_high),
        .flash_fail(flash_fail), .selftest_busy(selftest_busy), .selftest_fail(selftest_fail),
        .cksum_bad(cksum_bad), .capbuf_full(capbuf_full), .alarm1(alarm1), .alarm2(alarm2),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_src(input int b, input logic v);
        case (b)
            2: flash_fail = v;
            4: selftest_busy = v;
            5: selftest_fail = v;
            6: cksum_bad = v;
            7: capbuf_full = v;
            8: alarm1 = v;
            9: alarm2 = v;
            default: ;
        endcase
    endtask

    task automatic frame(input int edges);
        @(negedge clk); spi_cs_n = 1'b0;
        idle(2);
        for (int e = 0; e < edges; e++) begin
            spi_sclk = 1'b1; @(negedge clk);
            spi_sclk = 1'b0; @(negedge clk);
        end
        spi_cs_n = 1'b1;
        idle(4);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(A_LO, d); check("R1 low byte", d, 8'h00);
        rd(A_HI, d); check("R1 high byte", d, 8'h00);

        // R2/R3/R4 per-bit sweep of event sources
        for (int b = 2; b < 10; b++) begin
            if (b == 3) continue;
            @(negedge clk); set_src(b, 1'b1);
            @(negedge clk); set_src(b, 1'b0);
            idle(3);
            rd((b < 8) ? A_LO : A_HI, d);
            check($sformatf("R2 R3 bit %0d", b), d, 8'(1 << (b % 8)));
            rd((b < 8) ? A_LO : A_HI, d);
            check($sformatf("R4 bit %0d cleared", b), d, 8'h00);
        end

        // R6 supply levels gated by sample tick, re-latch after read
        @(negedge clk); supply_low = 1'b1;
        idle(3);
        rd(A_LO, d); check("R6 no tick no latch", d, 8'h00);
        @(negedge clk); sample_tick = 1'b1;
        @(negedge clk); sample_tick = 1'b0;
        rd(A_LO, d); check("R6 low latched", d, 8'h01);
        rd(A_LO, d); check("R6 cleared between ticks", d, 8'h00);
        @(negedge clk); sample_tick = 1'b1;
        @(negedge clk); sample_tick = 1'b0;
        rd(A_LO, d); check("R6 low re-latched", d, 8'h01);
        supply_low = 1'b0; supply_high = 1'b1;
        @(negedge clk); sample_tick = 1'b1;
        @(negedge clk); sample_tick = 1'b0; supply_high = 1'b0;
        rd(A_LO, d); check("R6 high latched", d, 8'h02);

        // R5 set in same cycle as clearing read
        @(negedge clk); cksum_bad = 1'b1; rd_en = 1'b1; rd_addr = A_LO;
        @(negedge clk); cksum_bad = 1'b0; rd_en = 1'b0; d = rd_data;
        check("R5 read before set", d, 8'h00);
        rd(A_LO, d); check("R5 flag survived read", d, 8'h40);

        // R8 miss read returns zero and does not clear
        @(negedge clk); flash_fail = 1'b1;
        @(negedge clk); flash_fail = 1'b0;
        rd(7'h14, d); check("R8 miss returns zero", d, 8'h00);
        rd(7'h11, d); check("R8 neighbour miss", d, 8'h00);
        rd(A_LO, d); check("R8 flag kept", d, 8'h04);

        // R7 sweep of SCLK edge counts
        for (int n = 0; n <= 34; n++) begin
            frame(n);
            rd(A_LO, d);
            check($sformatf("R7 edges %0d", n), d, ((n % 16) != 0) ? 8'h08 : 8'h00);
        end

        // R9 bad frame followed by good frame
        frame(5);
        frame(16);
        rd(A_LO, d); check("R9 bad frame flagged", d, 8'h08);
        frame(16);
        rd(A_LO, d); check("R9 counter restarted", d, 8'h00);
        frame(21);
        frame(11);
        rd(A_LO, d); check("R9 two bad frames", d, 8'h08);

        done = 1;
        finish_run();
    end
endmodule